// File: doc/BRIEF.md
# Delayed-Write Store Stage for a Direct-Mapped Data Cache

This block sits in the memory stage of a pipeline, in front of a direct-mapped data cache, and lets every store complete in a single cycle. A store only checks the tag in its own cycle. If the tag matches, its word address, data and byte mask are parked in a one-entry holding register. The parked write reaches the data array later, in the cycle in which the next hitting store does its own tag check. Loads read tag and data in one cycle. When a load targets the parked word, the parked bytes are merged over the array word, so the load sees the newest value.

The tag and data arrays are held inside the block. A line-fill port writes one data word and installs the line's tag and valid bit, and this is how lines come into the cache. Miss handling, refill sequencing and write-back belong to the surrounding logic. That logic raises the drain input in an idle cycle to push the parked write into the array, for example before it refills a line.

Top module: `dly_write_cache`

## Requirements
- R1: After reset there is no response (`rsp_valid` low) and every line is invalid, so the first load of any address misses.
- R2: The 14-bit word address splits into tag in bits [13:6], line index in bits [5:2] and word-in-line in bits [1:0]. A request hits when its line is valid and the stored tag equals its tag. `rsp_valid` and `rsp_hit` appear on the clock edge after the request cycle.
- R3: A store that hits does not write the data array in its own cycle. Its word address, data and byte mask are parked in the holding register.
- R4: A parked write is committed to the data array, under its byte mask, in the cycle of the next store that hits. That store then takes the holding register. This also applies when both stores target the same word.
- R5: A load whose word address equals the parked word address returns, for each byte lane, the parked byte where the parked mask bit is 1, and the array byte otherwise.
- R6: A store that misses reports `rsp_hit` low, writes nothing, and leaves the parked write pending and forwardable.
- R7: `flush` raised with no request drains the parked write into the data array in that cycle and empties the holding register.
- R8: `flush` raised in the same cycle as a request has no effect. The parked write stays pending.
- R9: A fill writes `fill_data` into the addressed word and marks the line valid with the fill address's tag. A fill takes effect only in a cycle with neither a request nor `flush`.
- R10: `rsp_rdata` carries load data for a load hit and is zero for a load miss and for every store response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 14 | Word address of the request |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte mask, bit n selects byte lane n |
| flush | input | 1 | Drain the parked write (idle cycles only) |
| fill_en | input | 1 | Line-fill write strobe |
| fill_addr | input | 14 | Word address of the fill |
| fill_data | input | 32 | Fill data word |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag check result of that request |
| rsp_rdata | output | 32 | Load data (zero for stores and misses) |

## Verification
A holding register that is wrongly cleared or never loaded shows up at the next load of the parked word: the load returns stale array bytes one cycle after it is issued. A drain that is skipped or misdirected stays hidden while the write is forwarded. It shows only once the holding register has moved on, or once a fill has rewritten the word. So the directed sequences always load the older address after a second store, or after a flush-and-fill, and every byte mask pattern is checked lane by lane on the load data.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int WADDR_W = 14;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int WOFF_W  = 2;
    localparam int BE_W    = DATA_W / 8;
    localparam int TAG_W   = WADDR_W - IDX_W - WOFF_W;
    localparam int LINES   = 1 << IDX_W;
    localparam int WORDS   = LINES << WOFF_W;

    typedef struct packed {
        logic               pend_valid;
        logic [WADDR_W-1:0] pend_waddr;
        logic [DATA_W-1:0]  pend_data;
        logic [BE_W-1:0]    pend_be;
        logic               rsp_valid;
        logic               rsp_hit;
        logic [DATA_W-1:0]  rsp_rdata;
    } dwc_state_t;
endpackage

// File: rtl/dwc_tag_array.sv
module dwc_tag_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q, valid_d;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];

    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        if (we) begin
            valid_d[wr_idx] = 1'b1;
            tag_d[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
        end else begin
            valid_q <= valid_d;
            tag_q   <= tag_d;
        end
    end

    // R9: a fill leaves its line valid on the following cycle
    p_fill_installs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/dwc_data_array.sv
module dwc_data_array #(
    parameter int AW     = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                we,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int WORDS = 1 << AW;
    localparam int BE_W  = DATA_W / 8;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] lane_mask;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_mask[g*8 +: 8] = {8{wr_be[g]}};
    end

    assign rd_data = mem_q[rd_addr];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[wr_addr] = (mem_q[wr_addr] & ~lane_mask) | (wr_data & lane_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/dwc_fwd_merge.sv
module dwc_fwd_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   arr_data,
    input  logic [DATA_W-1:0]   buf_data,
    input  logic [DATA_W/8-1:0] buf_be,
    input  logic                sel,
    output logic [DATA_W-1:0]   out_data
);
    localparam int BE_W = DATA_W / 8;

    for (genvar g = 0; g < BE_W; g++) begin : g_byte
        assign out_data[g*8 +: 8] = (sel && buf_be[g]) ? buf_data[g*8 +: 8] : arr_data[g*8 +: 8];
    end
endmodule

// File: rtl/dly_write_cache.sv
module dly_write_cache
    import dwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [WADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]    req_be,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [WADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [DATA_W-1:0]  rsp_rdata
);
    localparam int AW = IDX_W + WOFF_W;

    dwc_state_t st_q, st_d;

    logic [TAG_W-1:0]  req_tag, fill_tag;
    logic [IDX_W-1:0]  req_idx, fill_idx;
    logic              tag_hit;
    logic              store_hit, store_miss, drain_go, fill_go, fwd_sel;
    logic              arr_we;
    logic [AW-1:0]     arr_waddr;
    logic [BE_W-1:0]   arr_wbe;
    logic [DATA_W-1:0] arr_wdata, arr_rdata, load_data;

    assign req_tag  = req_addr[WADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[WOFF_W +: IDX_W];
    assign fill_tag = fill_addr[WADDR_W-1 -: TAG_W];
    assign fill_idx = fill_addr[WOFF_W +: IDX_W];

    assign store_hit  = req_valid && req_store && tag_hit;
    assign store_miss = req_valid && req_store && !tag_hit;
    assign drain_go   = st_q.pend_valid && (store_hit || (flush && !req_valid));
    assign fill_go    = fill_en && !req_valid && !flush;
    assign fwd_sel    = st_q.pend_valid && (st_q.pend_waddr == req_addr);

    assign arr_we    = drain_go || fill_go;
    assign arr_waddr = drain_go ? st_q.pend_waddr[AW-1:0] : fill_addr[AW-1:0];
    assign arr_wbe   = drain_go ? st_q.pend_be : {BE_W{1'b1}};
    assign arr_wdata = drain_go ? st_q.pend_data : fill_data;

    dwc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_idx),
        .rd_tag (req_tag),
        .hit    (tag_hit),
        .we     (fill_go),
        .wr_idx (fill_idx),
        .wr_tag (fill_tag)
    );

    dwc_data_array #(.AW(AW), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr[AW-1:0]),
        .rd_data (arr_rdata),
        .we      (arr_we),
        .wr_addr (arr_waddr),
        .wr_be   (arr_wbe),
        .wr_data (arr_wdata)
    );

    dwc_fwd_merge #(.DATA_W(DATA_W)) u_merge (
        .arr_data (arr_rdata),
        .buf_data (st_q.pend_data),
        .buf_be   (st_q.pend_be),
        .sel      (fwd_sel),
        .out_data (load_data)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = req_valid && tag_hit;
        st_d.rsp_rdata = (req_valid && !req_store && tag_hit) ? load_data : '0;
        if (store_hit) begin
            st_d.pend_valid = 1'b1;
            st_d.pend_waddr = req_addr;
            st_d.pend_data  = req_wdata;
            st_d.pend_be    = req_be;
        end else if (drain_go) begin
            st_d.pend_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_rdata = st_q.rsp_rdata;

    p_rsp_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid));

    p_store_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        store_hit |=> st_q.pend_valid && st_q.pend_waddr == $past(req_addr)
                      && st_q.pend_data == $past(req_wdata));

    p_drain_only_on_store_or_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && req_valid) |-> (req_store && tag_hit));

    p_miss_keeps_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_miss |=> $stable(st_q.pend_valid) && $stable(st_q.pend_waddr)
                       && $stable(st_q.pend_data));

    p_flush_idle_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !req_valid) |=> !st_q.pend_valid);

    p_flush_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid && !req_store) |=> $stable(st_q.pend_valid) && $stable(st_q.pend_waddr));

    p_miss_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> rsp_rdata == '0);
endmodule

// File: tb/sim_dly_write_cache.sv
module sim_dly_write_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, flush, fill_en;
    logic [13:0] req_addr, fill_addr;
    logic [31:0] req_wdata, fill_data;
    logic [3:0]  req_be;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dly_write_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .flush(flush),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [13:0] wa(input logic [7:0] t, input logic [3:0] i, input logic [1:0] w);
        return {t, i, w};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_store = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        flush = 0; fill_en = 0; fill_addr = '0; fill_data = '0;
    endtask

    task automatic cyc(input logic rv, input logic st, input logic [13:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic fl, input logic fe,
                       input logic [13:0] fa, input logic [31:0] fd);
        @(negedge clk);
        req_valid = rv; req_store = st; req_addr = a; req_wdata = d; req_be = be;
        flush = fl; fill_en = fe; fill_addr = fa; fill_data = fd;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_load(input logic [13:0] a);
        cyc(1, 0, a, '0, '0, 0, 0, '0, '0);
    endtask
    task automatic do_store(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be);
        cyc(1, 1, a, d, be, 0, 0, '0, '0);
    endtask
    task automatic do_fill(input logic [13:0] a, input logic [31:0] d);
        cyc(0, 0, '0, '0, '0, 0, 1, a, d);
    endtask
    task automatic do_flush();
        cyc(0, 0, '0, '0, '0, 1, 0, '0, '0);
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        do_load(wa(8'h12, 3, 1));
        chk("R1 first load misses", {31'b0, rsp_hit}, 32'h0);
        chk("R10 miss rdata zero", rsp_rdata, 32'h0);
    endtask

    task automatic t_fill_load();
        do_fill(wa(8'h12, 3, 1), 32'hAABBCCDD);
        do_load(wa(8'h12, 3, 1));
        chk("R2 rsp_valid one cycle later", {31'b0, rsp_valid}, 32'h1);
        chk("R9 fill makes hit", {31'b0, rsp_hit}, 32'h1);
        chk("R9 fill data", rsp_rdata, 32'hAABBCCDD);
        do_load(wa(8'h22, 3, 1));
        chk("R2 other tag misses", {31'b0, rsp_hit}, 32'h0);
        chk("R10 miss rdata zero", rsp_rdata, 32'h0);
    endtask

    task automatic t_store_forward();
        do_store(wa(8'h12, 3, 1), 32'h11223344, 4'b0011);
        chk("R3 store hit flag", {31'b0, rsp_hit}, 32'h1);
        chk("R10 store rdata zero", rsp_rdata, 32'h0);
        do_load(wa(8'h12, 3, 1));
        chk("R5 partial merge", rsp_rdata, 32'hAABB3344);
    endtask

    task automatic t_second_store();
        do_fill(wa(8'h12, 3, 2), 32'h55667788);
        do_store(wa(8'h12, 3, 2), 32'h99999999, 4'b1000);
        do_load(wa(8'h12, 3, 1));
        chk("R4 older store committed", rsp_rdata, 32'hAABB3344);
        do_load(wa(8'h12, 3, 2));
        chk("R5 top byte merge", rsp_rdata, 32'h99667788);
    endtask

    task automatic t_miss_store();
        do_store(wa(8'h44, 4, 1), 32'hFEEDFACE, 4'b1111);
        chk("R6 store miss flag", {31'b0, rsp_hit}, 32'h0);
        do_load(wa(8'h12, 3, 2));
        chk("R6 pending kept", rsp_rdata, 32'h99667788);
        do_fill(wa(8'h44, 4, 1), 32'h0F0F0F0F);
        do_load(wa(8'h44, 4, 1));
        chk("R6 miss data not written", rsp_rdata, 32'h0F0F0F0F);
    endtask

    task automatic t_flush_idle();
        do_flush();
        do_fill(wa(8'h12, 3, 2), 32'hCAFEF00D);
        do_load(wa(8'h12, 3, 2));
        chk("R7 flush empties buffer", rsp_rdata, 32'hCAFEF00D);
    endtask

    task automatic t_flush_busy();
        do_store(wa(8'h12, 3, 1), 32'hDEADBEEF, 4'b1111);
        cyc(1, 0, wa(8'h12, 3, 0), '0, '0, 1, 0, '0, '0);
        chk("R8 load with flush hits", {31'b0, rsp_hit}, 32'h1);
        chk("R8 load with flush data", rsp_rdata, 32'h0);
        do_fill(wa(8'h12, 3, 1), 32'h01010101);
        do_load(wa(8'h12, 3, 1));
        chk("R8 flush with request ignored", rsp_rdata, 32'hDEADBEEF);
        do_flush();
        do_load(wa(8'h12, 3, 1));
        chk("R7 drained value", rsp_rdata, 32'hDEADBEEF);
    endtask

    task automatic t_same_word();
        do_store(wa(8'h12, 3, 1), 32'h000000AA, 4'b0001);
        do_store(wa(8'h12, 3, 1), 32'h0000BB00, 4'b0010);
        do_load(wa(8'h12, 3, 1));
        chk("R4 same word back-to-back", rsp_rdata, 32'hDEADBBAA);
    endtask

    task automatic t_fill_blocked();
        cyc(1, 0, wa(8'h12, 3, 1), '0, '0, 0, 1, wa(8'h55, 5, 0), 32'h77777777);
        chk("R9 load beside fill", rsp_rdata, 32'hDEADBBAA);
        do_load(wa(8'h55, 5, 0));
        chk("R9 fill with request ignored", {31'b0, rsp_hit}, 32'h0);
        cyc(0, 0, '0, '0, '0, 1, 1, wa(8'h66, 6, 0), 32'h66666666);
        do_load(wa(8'h66, 6, 0));
        chk("R9 fill with flush ignored", {31'b0, rsp_hit}, 32'h0);
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1;
        t_reset();
        t_fill_load();
        t_store_forward();
        t_second_store();
        t_miss_store();
        t_flush_idle();
        t_flush_busy();
        t_same_word();
        t_fill_blocked();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule